// File: doc/BRIEF.md
# Paged Receive Ring Manager

This block steers incoming frame bytes into a circular receive area built from 256-byte pages. Two static configuration inputs give the area's bounds: the first page of the ring and the first page past its end. The block tracks the page where the next frame will begin and a guard page owned by the host. Each frame starts on a fresh page. The block keeps the first four bytes of that page for a header and writes the frame bytes after them, one byte per cycle. When the data fills the last page of the ring, it continues on the first page.

When the frame ends, the block writes a 32-bit header word to the frame's first page. The word holds the receive status supplied with the end strobe, the page where the following frame will begin, and the count of stored bytes, CRC bytes included. The host consumes frames in order. When it has finished with a frame, it returns the header's next-page value on the release port. The block then moves its guard page to the page just before that one.

A frame is dropped if it would need to write into the guard page. This can happen at the frame's start or at a page crossing partway through the frame. The block raises a one-cycle overwrite warning, ignores the rest of the frame, and leaves the start page unchanged. At the frame's end it reports the status with the missed-frame bit set.

Top module: `rx_page_ring`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), curr_page equals ring_lo and bnd_page equals ring_hi minus 1. mem_we, hdr_we, drop_we and ovw are all low.
- R2: rx_start begins a frame at curr_page. Each rx_valid byte is written one cycle later, with mem_we high and mem_addr = {page, offset}. The first byte goes to offset 4, and the following bytes go to consecutive addresses. rx_valid outside a frame (no rx_start since the last rx_end) writes nothing.
- R3: The byte after offset 255 of page ring_hi minus 1 is written at offset 0 of page ring_lo.
- R4: One cycle after rx_end, hdr_we pulses for a single cycle. hdr_addr is {first page of the frame, 8'h00}. hdr_word[7:0] is rx_status. hdr_word[31:16] is the number of bytes received in the frame, CRC bytes included.
- R5: hdr_word[15:8] is the page after the frame's last byte, with the 4+N stored bytes rounded up to whole pages and the ring wrap applied. curr_page takes this value at the same edge.
- R6: A pulse on rel_we with page P sets bnd_page to P minus 1. If P equals ring_lo, bnd_page becomes ring_hi minus 1 instead.
- R7: If curr_page equals bnd_page at rx_start, ovw pulses one cycle later, and no byte of that frame is written.
- R8: If a frame needs to begin writing a new page and that page equals bnd_page, ovw pulses and that byte and the rest of the frame are not written. curr_page stays at its value before the frame.
- R9: For a dropped frame, rx_end produces a one-cycle drop_we with drop_status = rx_status with bit 4 (missed frame) set, and no hdr_we.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ring_lo | input | 8 | First page of the ring |
| ring_hi | input | 8 | Page just past the ring |
| rel_we | input | 1 | Host release strobe |
| rel_page | input | 8 | Next-page value of the frame being released |
| rx_start | input | 1 | Frame start strobe |
| rx_valid | input | 1 | Frame byte strobe |
| rx_byte | input | 8 | Frame byte |
| rx_end | input | 1 | Frame end strobe |
| rx_status | input | 8 | Receive status, sampled with rx_end |
| mem_we | output | 1 | Data byte write strobe |
| mem_addr | output | 16 | Data byte address {page, offset} |
| mem_data | output | 8 | Data byte |
| hdr_we | output | 1 | Header write strobe |
| hdr_addr | output | 16 | Header address, the start of the frame's first page |
| hdr_word | output | 32 | {length, next page, status} |
| drop_we | output | 1 | Dropped-frame report strobe |
| drop_status | output | 8 | Status of the dropped frame, missed bit set |
| ovw | output | 1 | Overwrite warning pulse |
| curr_page | output | 8 | Page where the next frame starts |
| bnd_page | output | 8 | Guard page |

## Verification
The assertions check, on every cycle, that both pointers stay inside the ring and that no data byte ever lands in the guard page. They also check that no byte is written in the cycle after an overwrite warning, that a header and a drop report never appear together, and that a header's next page lies in the ring. The bench's scenarios are the only evidence for the exact byte placement, including the wrap from the last page to the first. They also cover the rounding of the next page, the length and status fields, and the choice between storing and dropping a frame. For this, the bench sweeps frame lengths around page edges in a six-page ring and compares each result against an arithmetic model of the ring.

// File: rtl/rx_page_ring.sv
module rx_page_ring (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [7:0]  ring_lo,
  input  logic [7:0]  ring_hi,
  input  logic        rel_we,
  input  logic [7:0]  rel_page,
  input  logic        rx_start,
  input  logic        rx_valid,
  input  logic [7:0]  rx_byte,
  input  logic        rx_end,
  input  logic [7:0]  rx_status,
  output logic        mem_we,
  output logic [15:0] mem_addr,
  output logic [7:0]  mem_data,
  output logic        hdr_we,
  output logic [15:0] hdr_addr,
  output logic [31:0] hdr_word,
  output logic        drop_we,
  output logic [7:0]  drop_status,
  output logic        ovw,
  output logic [7:0]  curr_page,
  output logic [7:0]  bnd_page
);
  localparam logic [7:0] HDR_BYTES = 8'd4;
  localparam logic [7:0] MISSED    = 8'h10;

  logic        active, dropping;
  logic [7:0]  first_page, wr_page, wr_off;
  logic [15:0] len;

  wire [7:0] wr_plus  = 8'(wr_page + 8'd1);
  wire [7:0] wr_inc   = (wr_plus == ring_hi) ? ring_lo : wr_plus;
  wire [7:0] next_pg  = (wr_off == 8'd0) ? wr_page : wr_inc;
  wire       hit_bnd  = (wr_off == 8'd0) && (wr_page == bnd_page);
  wire [7:0] rel_bnd  = (rel_page == ring_lo) ? 8'(ring_hi - 8'd1) : 8'(rel_page - 8'd1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      curr_page   <= ring_lo;
      bnd_page    <= 8'(ring_hi - 8'd1);
      active      <= 1'b0;
      dropping    <= 1'b0;
      first_page  <= 8'd0;
      wr_page     <= 8'd0;
      wr_off      <= 8'd0;
      len         <= 16'd0;
      mem_we      <= 1'b0;
      mem_addr    <= 16'd0;
      mem_data    <= 8'd0;
      hdr_we      <= 1'b0;
      hdr_addr    <= 16'd0;
      hdr_word    <= 32'd0;
      drop_we     <= 1'b0;
      drop_status <= 8'd0;
      ovw         <= 1'b0;
    end else begin
      mem_we  <= 1'b0;
      hdr_we  <= 1'b0;
      drop_we <= 1'b0;
      ovw     <= 1'b0;
      if (rel_we) bnd_page <= rel_bnd;
      if (rx_start) begin
        active     <= 1'b1;
        first_page <= curr_page;
        wr_page    <= curr_page;
        wr_off     <= HDR_BYTES;
        len        <= 16'd0;
        dropping   <= (curr_page == bnd_page);
        ovw        <= (curr_page == bnd_page);
      end else if (rx_valid && active && !dropping) begin
        if (hit_bnd) begin
          dropping <= 1'b1;
          ovw      <= 1'b1;
        end else begin
          mem_we   <= 1'b1;
          mem_addr <= {wr_page, wr_off};
          mem_data <= rx_byte;
          len      <= len + 16'd1;
          wr_off   <= wr_off + 8'd1;
          if (wr_off == 8'hff) wr_page <= wr_inc;
        end
      end else if (rx_end && active) begin
        active <= 1'b0;
        if (dropping) begin
          drop_we     <= 1'b1;
          drop_status <= rx_status | MISSED;
        end else begin
          hdr_we    <= 1'b1;
          hdr_addr  <= {first_page, 8'h00};
          hdr_word  <= {len, next_pg, rx_status};
          curr_page <= next_pg;
        end
      end
    end
  end

  assert_curr_in_ring_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (curr_page >= ring_lo) && (curr_page < ring_hi));
  assert_bnd_in_ring_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bnd_page >= ring_lo) && (bnd_page < ring_hi));
  assert_no_write_bnd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> (mem_addr[15:8] != bnd_page) && (mem_addr[15:8] >= ring_lo) && (mem_addr[15:8] < ring_hi));
  assert_quiet_after_ovw_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovw |=> !mem_we);
  assert_hdr_xor_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(hdr_we && drop_we));
  assert_hdr_next_in_ring_R4: assert property (@(posedge clk) disable iff (!rst_n)
    hdr_we |-> (hdr_word[15:8] >= ring_lo) && (hdr_word[15:8] < ring_hi));
endmodule

// File: tb/tb_rx_page_ring.sv
module tb_rx_page_ring;
  localparam int LO = 2;
  localparam int HI = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rel_we = 1'b0, rx_start = 1'b0, rx_valid = 1'b0, rx_end = 1'b0;
  logic [7:0] rel_page = '0, rx_byte = '0, rx_status = '0;
  logic mem_we, hdr_we, drop_we, ovw;
  logic [15:0] mem_addr, hdr_addr;
  logic [7:0] mem_data, drop_status, curr_page, bnd_page;
  logic [31:0] hdr_word;

  always #5 clk = ~clk;

  rx_page_ring dut (
    .clk(clk), .rst_n(rst_n), .ring_lo(8'(LO)), .ring_hi(8'(HI)),
    .rel_we(rel_we), .rel_page(rel_page), .rx_start(rx_start), .rx_valid(rx_valid),
    .rx_byte(rx_byte), .rx_end(rx_end), .rx_status(rx_status),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_data(mem_data),
    .hdr_we(hdr_we), .hdr_addr(hdr_addr), .hdr_word(hdr_word),
    .drop_we(drop_we), .drop_status(drop_status), .ovw(ovw),
    .curr_page(curr_page), .bnd_page(bnd_page));

  logic [7:0] mem [0:2047];
  int hdr_cnt = 0, drop_cnt = 0, ovw_cnt = 0, wr_cnt = 0;
  logic [31:0] last_hw;
  logic [15:0] last_ha;
  logic [7:0] last_ds;

  always @(posedge clk) begin
    if (mem_we) begin mem[mem_addr[10:0]] <= mem_data; wr_cnt <= wr_cnt + 1; end
    if (hdr_we) begin hdr_cnt <= hdr_cnt + 1; last_hw <= hdr_word; last_ha <= hdr_addr; end
    if (drop_we) begin drop_cnt <= drop_cnt + 1; last_ds <= drop_status; end
    if (ovw) ovw_cnt <= ovw_cnt + 1;
  end

  int checks = 0, errors = 0;
  int m_curr, m_bnd;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int wrapp(input int p);
    return (p >= HI) ? p - HI + LO : p;
  endfunction

  task automatic release_to(input int v);
    int e;
    @(negedge clk); rel_we = 1'b1; rel_page = 8'(v);
    @(negedge clk); rel_we = 1'b0;
    e = (v == LO) ? HI - 1 : v - 1;
    chk(bnd_page == 8'(e), "R6 guard page after release", bnd_page, e);
    m_bnd = e;
  endtask

  task automatic frame(input int n, input logic [7:0] st, input logic [7:0] seed);
    int used, p, nxt, h0, d0, o0, bad, start_full;
    bit drop, wraps;
    used = (n + 4 + 255) / 256;
    p = m_curr;
    start_full = (m_curr == m_bnd);
    drop = start_full;
    wraps = 0;
    for (int k = 1; k < used; k++) begin
      if (p + 1 >= HI) wraps = 1;
      p = wrapp(p + 1);
      if (p == m_bnd) drop = 1;
    end
    nxt = wrapp(p + 1);
    h0 = hdr_cnt; d0 = drop_cnt; o0 = ovw_cnt;
    @(negedge clk); rx_start = 1'b1;
    @(negedge clk); rx_start = 1'b0;
    for (int i = 0; i < n; i++) begin
      rx_valid = 1'b1; rx_byte = 8'(seed + i);
      @(negedge clk);
    end
    rx_valid = 1'b0; rx_end = 1'b1; rx_status = st;
    @(negedge clk); rx_end = 1'b0;
    repeat (2) @(negedge clk);
    if (drop) begin
      chk(drop_cnt == d0 + 1, "R9 drop report count", drop_cnt - d0, 1);
      chk(last_ds == (st | 8'h10), "R9 drop status missed bit", last_ds, st | 8'h10);
      chk(hdr_cnt == h0, "R9 no header on drop", hdr_cnt - h0, 0);
      if (start_full) chk(ovw_cnt == o0 + 1, "R7 warning at full start", ovw_cnt - o0, 1);
      else            chk(ovw_cnt == o0 + 1, "R8 warning at page crossing", ovw_cnt - o0, 1);
      chk(curr_page == 8'(m_curr), "R8 start page kept", curr_page, m_curr);
    end else begin
      chk(hdr_cnt == h0 + 1, "R4 one header", hdr_cnt - h0, 1);
      chk(last_ha == 16'(m_curr * 256), "R4 header address", last_ha, m_curr * 256);
      chk(last_hw[31:16] == 16'(n), "R4 length field", last_hw[31:16], n);
      chk(last_hw[7:0] == st, "R4 status field", last_hw[7:0], st);
      chk(last_hw[15:8] == 8'(nxt), "R5 next page field", last_hw[15:8], nxt);
      chk(curr_page == 8'(nxt), "R5 start page advanced", curr_page, nxt);
      chk(ovw_cnt == o0, "R7 no warning on stored frame", ovw_cnt - o0, 0);
      bad = 0;
      for (int i = 0; i < n; i++) begin
        int pos, a;
        pos = 4 + i;
        a = wrapp(m_curr + pos / 256) * 256 + pos % 256;
        if (mem[a] != 8'(seed + i)) bad++;
      end
      if (wraps) chk(bad == 0, "R3 bytes across ring wrap", bad, 0);
      else       chk(bad == 0, "R2 bytes in place", bad, 0);
      m_curr = nxt;
    end
  endtask

  initial begin
    int lens [8] = '{60, 251, 252, 253, 300, 508, 509, 1000};
    int w0;
    repeat (3) @(negedge clk);
    chk(curr_page == 8'(LO), "R1 start page after reset", curr_page, LO);
    chk(bnd_page == 8'(HI - 1), "R1 guard page after reset", bnd_page, HI - 1);
    chk(!mem_we && !hdr_we && !drop_we && !ovw, "R1 strobes low", 0, 0);
    rst_n = 1'b1;
    m_curr = LO; m_bnd = HI - 1;

    w0 = wr_cnt;
    @(negedge clk); rx_valid = 1'b1; rx_byte = 8'h5a;
    repeat (4) @(negedge clk);
    rx_valid = 1'b0;
    repeat (2) @(negedge clk);
    chk(wr_cnt == w0, "R2 bytes outside frame ignored", wr_cnt - w0, 0);

    for (int r = 0; r < 4; r++) begin
      for (int j = 0; j < 8; j++) begin
        frame(lens[j], 8'(j * 37 + r), 8'(r * 50 + j * 13));
        if (r != 0) release_to(m_curr);
      end
    end

    release_to(m_curr);
    frame(1300, 8'h21, 8'h77);
    release_to(m_curr);
    frame(1276, 8'h01, 8'h31);
    frame(60, 8'h01, 8'h09);
    release_to(m_curr);
    frame(64, 8'h41, 8'h44);
    release_to(LO);
    release_to(HI - 1);
    release_to(m_curr);
    frame(700, 8'h81, 8'h12);

    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #2000000;
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule